// File: doc/BRIEF.md
# Feature Select Command Decoder

This block interprets a host command that selects or configures device features. Each command arrives as an 8-bit feature code and an 8-bit configuration value, qualified by a one-cycle strobe. Most codes come in pairs, one to turn a feature on and one to turn it off. Two codes store the configuration value in a register instead of changing a flag. A few codes are accepted without any effect. Every other code is refused: the command is aborted and no stored state changes.

The decoder keeps seven persistent feature flags, a transfer-mode byte and a current-source capability byte. It reports completion and abort status in the cycle after the strobe. The byte-wide transfer flag also drives the data path. While that flag is set, the upper part of each data word is forced to zero, the 16-bit I/O indicator stays low for data register accesses, and a DMA request raises an error pulse instead of being serviced.

Top module: `feat_cmd_decoder`

## Requirements
- R1: Code 01h sets the byte-wide transfer flag (`byte_mode`) and code 81h clears it.
- R2: Codes 02h/82h set/clear `wcache_en`; 05h/85h set/clear `apm_en`; 09h/89h set/clear `xpwr_en`; 0Ah/8Ah set/clear `pl1_en`.
- R3: Code AAh sets `rla_en` and 55h clears it; code CCh sets `soft_dflt_en` and 66h clears it.
- R4: Code 03h loads `cmd_cfg` into `xfer_mode`; code 9Ah loads `cmd_cfg` into `isrc_cap`.
- R5: Codes 69h, 96h, 97h and BBh complete with `done`=1 and `abort`=0, and change no flag or stored value.
- R6: Any code not named in R1 to R5 completes with `done`=1 and `abort`=1, and changes no flag or stored value.
- R7: `done` is high for exactly the one cycle that follows a cycle with `cmd_stb` high; `abort` is only ever high together with `done`.
- R8: While `byte_mode`=1, `dev_wdata` equals `host_wdata` with bits above bit 7 forced to zero, and `io16_act` is 0. Otherwise `dev_wdata` equals `host_wdata` and `io16_act` equals `data_acc`.
- R9: `dma_err` is high in the cycle after a cycle in which `dma_req` and `byte_mode` were both high, and low otherwise.
- R10: While `rst_n` is low, the flags return to their defaults: `wcache_en`=1, `rla_en`=1 and every other flag 0. `xfer_mode`, `isrc_cap`, `done`, `abort` and `dma_err` return to 0.
- R11: The flags, `xfer_mode` and `isrc_cap` change only at a clock edge where `cmd_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_stb | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Feature code |
| cmd_cfg | input | 8 | Configuration value |
| done | output | 1 | Command completed (status valid) |
| abort | output | 1 | Command refused |
| byte_mode | output | 1 | Byte-wide transfer flag |
| wcache_en | output | 1 | Write cache enable |
| apm_en | output | 1 | Advanced power management enable |
| xpwr_en | output | 1 | Extended power operations enable |
| pl1_en | output | 1 | Power level 1 commands enable |
| rla_en | output | 1 | Read look-ahead enable |
| soft_dflt_en | output | 1 | Restore defaults on soft reset |
| xfer_mode | output | 8 | Stored transfer mode |
| isrc_cap | output | 8 | Stored host current-source capability |
| data_acc | input | 1 | Data register access in progress |
| host_wdata | input | 16 | Data word from host side |
| dev_wdata | output | 16 | Data word to the device data path |
| io16_act | output | 1 | 16-bit I/O indicator |
| dma_req | input | 1 | DMA transfer request |
| dma_err | output | 1 | DMA refused because byte-wide mode is set |

## Verification
The bound checker tests on every cycle that status follows each strobe by exactly one cycle, that an abort never changes stored state, and that nothing stored moves without a strobe. It also tests that the 16-bit indicator stays low in byte-wide mode and that DMA errors follow the requests that cause them. Which code sets or clears which flag, the values loaded by 03h and 9Ah, the masking of the upper byte, and the reset defaults can only be shown by the bench's scenarios. The bench walks every code, both paired and refused, and compares the outputs against its model.

// File: rtl/feat_pkg.sv
package feat_pkg;

   localparam int NFLAG = 7;
   localparam int IDX_W = 3;

   // flag slots inside the bank
   localparam int FL_BYTE  = 0;
   localparam int FL_WCACH = 1;
   localparam int FL_APM   = 2;
   localparam int FL_XPWR  = 3;
   localparam int FL_PL1   = 4;
   localparam int FL_RLA   = 5;
   localparam int FL_SDFLT = 6;

   typedef enum logic [2:0] {
      ACT_ABORT = 3'd0,
      ACT_SET   = 3'd1,
      ACT_CLR   = 3'd2,
      ACT_XFER  = 3'd3,
      ACT_ISRC  = 3'd4,
      ACT_NOP   = 3'd5
   } act_e;

   typedef struct packed {
      act_e             act;
      logic [IDX_W-1:0] idx;
   } dec_t;

endpackage

// File: rtl/feat_code_lut.sv
module feat_code_lut
   import feat_pkg::*;
(
   input  logic [7:0] code,
   output dec_t       dec
);

   always_comb begin
      dec.act = ACT_ABORT;
      dec.idx = '0;
      unique case (code)
         8'h01: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_BYTE);  end
         8'h81: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_BYTE);  end
         8'h02: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_WCACH); end
         8'h82: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_WCACH); end
         8'h05: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_APM);   end
         8'h85: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_APM);   end
         8'h09: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_XPWR);  end
         8'h89: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_XPWR);  end
         8'h0A: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_PL1);   end
         8'h8A: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_PL1);   end
         // inverted pair: the low code turns the feature off
         8'hAA: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_RLA);   end
         8'h55: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_RLA);   end
         8'hCC: begin dec.act = ACT_SET; dec.idx = IDX_W'(FL_SDFLT); end
         8'h66: begin dec.act = ACT_CLR; dec.idx = IDX_W'(FL_SDFLT); end
         8'h03: dec.act = ACT_XFER;
         8'h9A: dec.act = ACT_ISRC;
         8'h69, 8'h96, 8'h97, 8'hBB: dec.act = ACT_NOP;
         default: dec.act = ACT_ABORT;
      endcase
   end

endmodule

// File: rtl/feat_flag_bank.sv
module feat_flag_bank
   import feat_pkg::*;
#(
   parameter int             CFG_W = 8,
   parameter logic [NFLAG-1:0] DFLT = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stb,
   input  dec_t             dec,
   input  logic [CFG_W-1:0] cfg,
   output logic [NFLAG-1:0] flag_q,
   output logic [CFG_W-1:0] xfer_q,
   output logic [CFG_W-1:0] isrc_q
);

   for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
      logic hit;
      assign hit = stb && (dec.idx == IDX_W'(gi));
      always_ff @(posedge clk) begin
         if (!rst_n)
            flag_q[gi] <= DFLT[gi];
         else if (hit && dec.act == ACT_SET)
            flag_q[gi] <= 1'b1;
         else if (hit && dec.act == ACT_CLR)
            flag_q[gi] <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= '0;
         isrc_q <= '0;
      end else if (stb) begin
         if (dec.act == ACT_XFER) xfer_q <= cfg;
         if (dec.act == ACT_ISRC) isrc_q <= cfg;
      end
   end

endmodule

// File: rtl/feat_bus_ctrl.sv
module feat_bus_ctrl #(
   parameter int DATA_W = 16,
   parameter int LOW_W  = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_mode,
   input  logic              data_acc,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic              dma_req,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              io16_act,
   output logic              dma_err
);

   localparam int HI_W = DATA_W - LOW_W;

   assign dev_wdata = byte_mode ? {{HI_W{1'b0}}, host_wdata[LOW_W-1:0]} : host_wdata;
   assign io16_act  = data_acc && !byte_mode;

   always_ff @(posedge clk) begin
      if (!rst_n) dma_err <= 1'b0;
      else        dma_err <= dma_req && byte_mode;
   end

endmodule

// File: rtl/feat_cmd_decoder.sv
module feat_cmd_decoder
   import feat_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CFG_W  = 8,
   parameter logic [NFLAG-1:0] FLAG_DFLT = 7'b010_0010
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_stb,
   input  logic [7:0]        cmd_code,
   input  logic [CFG_W-1:0]  cmd_cfg,
   output logic              done,
   output logic              abort,
   output logic              byte_mode,
   output logic              wcache_en,
   output logic              apm_en,
   output logic              xpwr_en,
   output logic              pl1_en,
   output logic              rla_en,
   output logic              soft_dflt_en,
   output logic [CFG_W-1:0]  xfer_mode,
   output logic [CFG_W-1:0]  isrc_cap,
   input  logic              data_acc,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] dev_wdata,
   output logic              io16_act,
   input  logic              dma_req,
   output logic              dma_err
);

   localparam int LOW_W = 8;

   if (DATA_W <= LOW_W) begin : g_bad_data_w
      $error("DATA_W must exceed the byte lane width");
   end
   if (CFG_W < 1) begin : g_bad_cfg_w
      $error("CFG_W must be at least 1");
   end
   if (FLAG_DFLT[FL_BYTE] != 1'b0) begin : g_bad_dflt
      $error("byte-wide mode must default to off");
   end

   dec_t             dec;
   logic [NFLAG-1:0] flag_q;

   feat_code_lut u_lut (
      .code (cmd_code),
      .dec  (dec)
   );

   feat_flag_bank #(.CFG_W(CFG_W), .DFLT(FLAG_DFLT)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .stb    (cmd_stb),
      .dec    (dec),
      .cfg    (cmd_cfg),
      .flag_q (flag_q),
      .xfer_q (xfer_mode),
      .isrc_q (isrc_cap)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done  <= 1'b0;
         abort <= 1'b0;
      end else begin
         done  <= cmd_stb;
         abort <= cmd_stb && (dec.act == ACT_ABORT);
      end
   end

   assign byte_mode    = flag_q[FL_BYTE];
   assign wcache_en    = flag_q[FL_WCACH];
   assign apm_en       = flag_q[FL_APM];
   assign xpwr_en      = flag_q[FL_XPWR];
   assign pl1_en       = flag_q[FL_PL1];
   assign rla_en       = flag_q[FL_RLA];
   assign soft_dflt_en = flag_q[FL_SDFLT];

   feat_bus_ctrl #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_bus (
      .clk        (clk),
      .rst_n      (rst_n),
      .byte_mode  (flag_q[FL_BYTE]),
      .data_acc   (data_acc),
      .host_wdata (host_wdata),
      .dma_req    (dma_req),
      .dev_wdata  (dev_wdata),
      .io16_act   (io16_act),
      .dma_err    (dma_err)
   );

endmodule

// File: rtl/feat_cmd_chk.sv
module feat_cmd_chk
   import feat_pkg::*;
#(
   parameter int CFG_W = 8
)(
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_stb,
   input logic             done,
   input logic             abort,
   input logic [NFLAG-1:0] flag_q,
   input logic [CFG_W-1:0] xfer_mode,
   input logic [CFG_W-1:0] isrc_cap,
   input logic             io16_act,
   input logic             dma_req,
   input logic             dma_err
);

   logic [NFLAG+2*CFG_W-1:0] state;
   assign state = {flag_q, xfer_mode, isrc_cap};

   // R7
   done_follows_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_stb |=> done);
   // R7
   no_stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb |=> !done);
   // R7
   abort_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> done);
   // R6
   abort_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort |-> $stable(state));
   // R11
   idle_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_stb |=> $stable(state));
   // R8
   no_io16_in_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[FL_BYTE] |-> !io16_act);
   // R9
   dma_err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dma_req && flag_q[FL_BYTE]) |=> dma_err);
   // R9
   dma_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dma_req && flag_q[FL_BYTE]) |=> !dma_err);

endmodule

bind feat_cmd_decoder feat_cmd_chk #(.CFG_W(CFG_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_stb   (cmd_stb),
   .done      (done),
   .abort     (abort),
   .flag_q    (flag_q),
   .xfer_mode (xfer_mode),
   .isrc_cap  (isrc_cap),
   .io16_act  (io16_act),
   .dma_req   (dma_req),
   .dma_err   (dma_err)
);

// File: tb/sim_feat_cmd_decoder.sv
module sim_feat_cmd_decoder;

   localparam int CLK_P = 10;
   localparam int WD_CYC = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_stb = 1'b0;
   logic [7:0]  cmd_code = '0;
   logic [7:0]  cmd_cfg = '0;
   logic        data_acc = 1'b0;
   logic [15:0] host_wdata = '0;
   logic        dma_req = 1'b0;
   logic        done, abort, byte_mode, wcache_en, apm_en, xpwr_en, pl1_en, rla_en, soft_dflt_en;
   logic [7:0]  xfer_mode, isrc_cap;
   logic [15:0] dev_wdata;
   logic        io16_act, dma_err;

   feat_cmd_decoder u0 (
      .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code), .cmd_cfg(cmd_cfg),
      .done(done), .abort(abort), .byte_mode(byte_mode), .wcache_en(wcache_en),
      .apm_en(apm_en), .xpwr_en(xpwr_en), .pl1_en(pl1_en), .rla_en(rla_en),
      .soft_dflt_en(soft_dflt_en), .xfer_mode(xfer_mode), .isrc_cap(isrc_cap),
      .data_acc(data_acc), .host_wdata(host_wdata), .dev_wdata(dev_wdata),
      .io16_act(io16_act), .dma_req(dma_req), .dma_err(dma_err)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_cmp = 0;
   int n_bad = 0;
   int cyc = 0;

   // reference model state
   bit [6:0] m_fl;
   int       m_xfer, m_isrc;
   bit       m_done, m_abort, m_dmaerr, m_nop;
   byte unsigned on_codes[7]  = '{8'h01, 8'h02, 8'h05, 8'h09, 8'h0A, 8'hAA, 8'hCC};
   byte unsigned off_codes[7] = '{8'h81, 8'h82, 8'h85, 8'h89, 8'h8A, 8'h55, 8'h66};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fl = 7'b010_0010; m_xfer = 0; m_isrc = 0;
         m_done = 0; m_abort = 0; m_dmaerr = 0; m_nop = 0;
      end else begin
         m_dmaerr = dma_req && m_fl[0];
         m_done = cmd_stb;
         m_abort = 0;
         m_nop = 0;
         if (cmd_stb) begin
            bit known;
            known = 0;
            for (int i = 0; i < 7; i++) begin
               if (cmd_code == on_codes[i])  begin m_fl[i] = 1; known = 1; end
               if (cmd_code == off_codes[i]) begin m_fl[i] = 0; known = 1; end
            end
            if (cmd_code == 8'h03) begin m_xfer = cmd_cfg; known = 1; end
            if (cmd_code == 8'h9A) begin m_isrc = cmd_cfg; known = 1; end
            if (cmd_code inside {8'h69, 8'h96, 8'h97, 8'hBB}) begin m_nop = 1; known = 1; end
            m_abort = !known;
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   always @(negedge clk) begin
      string p;
      p = rst_n ? "" : "R10 ";
      chk({p, "R7 done"}, done, m_done);
      chk({p, m_nop ? "R5 abort" : "R6/R7 abort"}, abort, m_abort);
      chk({p, "R1/R11 byte_mode"}, byte_mode, m_fl[0]);
      chk({p, "R2/R11 wcache_en"}, wcache_en, m_fl[1]);
      chk({p, "R2 apm_en"}, apm_en, m_fl[2]);
      chk({p, "R2 xpwr_en"}, xpwr_en, m_fl[3]);
      chk({p, "R2 pl1_en"}, pl1_en, m_fl[4]);
      chk({p, "R3/R11 rla_en"}, rla_en, m_fl[5]);
      chk({p, "R3 soft_dflt_en"}, soft_dflt_en, m_fl[6]);
      chk({p, "R4 xfer_mode"}, xfer_mode, m_xfer);
      chk({p, "R4 isrc_cap"}, isrc_cap, m_isrc);
      chk("R8 io16_act", io16_act, data_acc && !m_fl[0]);
      chk("R8 dev_wdata", dev_wdata, m_fl[0] ? (host_wdata & 16'h00FF) : host_wdata);
      chk({p, "R9 dma_err"}, dma_err, m_dmaerr);
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_CYC) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic step(input bit stb, input byte unsigned code, input byte unsigned cfg);
      @(posedge clk);
      #(CLK_P/4);
      cmd_stb    = stb;
      cmd_code   = code;
      cmd_cfg    = cfg;
      data_acc   = 1'($urandom);
      dma_req    = 1'($urandom);
      host_wdata = 16'($urandom);
   endtask

   initial begin
      repeat (3) step(0, 8'h00, 8'h00);
      #(CLK_P/4) rst_n = 1'b1;
      repeat (4) step(0, 8'h00, 8'h00);
      // R1 byte-wide on, data path checks R8/R9 under random traffic
      step(1, 8'h01, 8'h00);
      repeat (6) step(0, 8'h00, 8'h00);
      // R4 stored values
      step(1, 8'h03, 8'h45);
      step(1, 8'h9A, 8'h12);
      // R3 inverted pairs, back to back
      step(1, 8'h55, 8'h00);
      step(1, 8'hAA, 8'h00);
      step(1, 8'hCC, 8'h00);
      step(1, 8'h66, 8'h00);
      // R5 no-ops
      step(1, 8'h69, 8'h77);
      step(1, 8'h96, 8'h77);
      step(1, 8'h97, 8'h77);
      step(1, 8'hBB, 8'h77);
      // R6 refused codes
      step(1, 8'h00, 8'h33);
      step(1, 8'hFF, 8'h33);
      step(1, 8'h04, 8'h33);
      step(0, 8'h00, 8'h00);
      // R2 pairs
      step(1, 8'h82, 8'h00);
      step(1, 8'h05, 8'h00);
      step(1, 8'h09, 8'h00);
      step(1, 8'h0A, 8'h00);
      step(1, 8'h02, 8'h00);
      step(1, 8'h81, 8'h00);
      repeat (4) step(0, 8'h00, 8'h00);
      // walk every code, alternating gaps
      for (int c = 0; c < 256; c++) begin
         step(1, 8'(c), 8'($urandom));
         if (c % 3 == 0) step(0, 8'(c), 8'h00);
      end
      for (int c = 255; c >= 0; c--) step(1, 8'(c), 8'($urandom));
      // R10 reset in mid-run
      @(posedge clk); #(CLK_P/4) rst_n = 1'b0;
      repeat (3) step(1, 8'h01, 8'h00);
      #(CLK_P/4) rst_n = 1'b1;
      repeat (4) step(0, 8'h00, 8'h00);
      @(negedge clk);
      @(posedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule